// File: doc/BRIEF.md
# Quadrature-Capable Timer Channel

This block is one 16-bit timer channel. Its counter advances on enable pulses from one of eight clock sources. Four of the sources are internal divisions of the system clock, and four are external pulse inputs whose rising edges are synchronised before use. Software reads and writes the counter, a control register, two general registers and a status flag over a plain single-cycle register bus. Read data is combinational from the address. A write takes effect on the clock edge at which it is presented.

Each general register works either as a compare value or as a capture target. A capture copies the counter on a rising edge of its capture input. Either register can be chosen as the source that returns the counter to zero. In phase counting mode the counter ignores the selected clock source. It then follows a pair of quadrature inputs, counting up or down. A wrap in either direction raises one shared overflow flag. Software clears that flag with a two-step handshake: it reads the status register while the flag is set, then writes 0. The channel carries no streaming data, so every port is a plain control or status pin and there is no valid/ready handshake.

Top module: `timer_channel`

## Requirements
- R1: After reset, the counter, both general registers, the control register and the overflow flag all read as zero.
- R2: Control bits [2:0] choose the count source. Values 0 to 3 advance the counter once every 1, 2, 4 or 8 clock cycles. Values 4 to 7 advance it once per rising edge of `ext_clk[sel-4]`, after a two-stage synchroniser. An unselected external input has no effect.
- R3: Bus addresses are: 0 control, 1 counter, 2 register A, 3 register B, 4 status (flag in bit 0). A bus write to the counter sets it to the written value, even when a count pulse falls in the same cycle. The next count continues from that value.
- R4: Control bits [4:3] choose the clear source: 01 means register A, 10 means register B, and 00 or 11 means no clearing. A register whose mode bit is 0 is a compare register. If a count pulse arrives while the counter equals the selected compare register, the counter goes to 0x0000 instead of incrementing.
- R5: A register whose mode bit is 1 is a capture register. The mode bit for A is control bit 6, and for B it is control bit 7. A synchronised rising edge on `cap_in[0]` (for A) or `cap_in[1]` (for B) copies the counter into that register. If the clear source selects that register, the counter clears to 0x0000 in the same cycle. Otherwise the counter is left unchanged.
- R6: A count step from 0xFFFF to 0x0000 sets the overflow flag. The flag is visible on `ovf_flag` and in status bit 0.
- R7: With control bit 5 set (phase counting), the clock source is ignored. Each valid quadrature edge moves the counter by one: up when `quad_a` leads `quad_b` (states AB 00, 10, 11, 01, 00), and down for the reverse order.
- R8: A count step from 0x0000 to 0xFFFF in phase counting mode sets the same overflow flag.
- R9: A change of both quadrature inputs between two samples is ignored, and the counter holds its value.
- R10: A write of 0 to status bit 0 clears the flag only if an earlier status read saw the flag set. A write without such a read, or after a read that saw 0, leaves the flag set. Any status write uses up the earlier read.
- R11: If a flag-setting wrap and a flag-clearing status write fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, acts at the clock edge |
| bus_rd | input | 1 | Read strobe; a status read that sees the flag set arms the clear |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| ext_clk | input | 4 | External count pulse inputs |
| quad_a | input | 1 | Quadrature phase A |
| quad_b | input | 1 | Quadrature phase B |
| cap_in | input | 2 | Capture inputs for registers A and B |
| ovf_flag | output | 1 | Overflow/underflow flag |

## Verification
Two pairs of functions can fall in the same clock cycle. The first pair is a bus write to the counter and a count pulse. The bench provokes it by writing the counter while the every-cycle source is running. It judges the pair by reading back the exact written value one cycle later, then the value plus one. The second pair is a flag-setting wrap and an armed flag-clearing write. The bench first arms the flag with a status read. It then loads 0xFFFE and issues the status write two cycles later, so it lands on the wrap edge. The collision is judged by `ovf_flag` still being high afterwards.

// File: rtl/timer_pkg.sv
package timer_pkg;

  localparam int A_CTRL = 0;
  localparam int A_CNT  = 1;
  localparam int A_GRA  = 2;
  localparam int A_GRB  = 3;
  localparam int A_STAT = 4;

  typedef enum logic [1:0] {
    CLR_NONE = 2'b00,
    CLR_A    = 2'b01,
    CLR_B    = 2'b10,
    CLR_RSV  = 2'b11
  } clr_sel_e;

  typedef struct packed {
    logic       cap_b;
    logic       cap_a;
    logic       phase;
    clr_sel_e   clr;
    logic [2:0] src;
  } ctrl_t;

endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int W    = 1,
  parameter bit EDGE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= din;
      s2 <= s1;
      s3 <= s2;
    end
  end

  generate
    if (EDGE) begin : g_rise
      assign dout = s2 & ~s3;
    end else begin : g_level
      assign dout = s2;
    end
  endgenerate
endmodule

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel #(
  parameter int N_INT = 4,
  parameter int N_EXT = 4,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] src,
  input  logic [N_EXT-1:0] ext_rise,
  output logic             tick
);
  localparam int PW = (N_INT > 1) ? N_INT - 1 : 1;

  logic [PW-1:0]          pre_q;
  logic [N_INT-1:0]       int_tick;
  logic [N_INT+N_EXT-1:0] all_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  assign int_tick[0] = 1'b1;
  generate
    for (genvar k = 1; k < N_INT; k++) begin : g_div
      assign int_tick[k] = &pre_q[k-1:0];
    end
  endgenerate

  assign all_tick = {ext_rise, int_tick};
  assign tick     = all_tick[src];
endmodule

// File: rtl/tmr_quad_dec.sv
module tmr_quad_dec (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pa,
  input  logic pb,
  output logic up,
  output logic dn
);
  logic [1:0] prev_q, cur, diff;

  function automatic logic [1:0] phase_pos(input logic a, input logic b);
    case ({a, b})
      2'b00:   phase_pos = 2'd0;
      2'b10:   phase_pos = 2'd1;
      2'b11:   phase_pos = 2'd2;
      default: phase_pos = 2'd3;
    endcase
  endfunction

  assign cur  = phase_pos(pa, pb);
  assign diff = cur - prev_q;
  assign up   = en && (diff == 2'd1);
  assign dn   = en && (diff == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 2'd0;
    else        prev_q <= cur;
  end
endmodule

// File: rtl/timer_channel.sv
module timer_channel
  import timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3,
  parameter int N_INT  = 4,
  parameter int N_EXT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [N_EXT-1:0]  ext_clk,
  input  logic              quad_a,
  input  logic              quad_b,
  input  logic [1:0]        cap_in,
  output logic              ovf_flag
);
  localparam int N_GR = 2;
  localparam int EW   = N_EXT + N_GR;

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] gr_q [N_GR];
  logic             flag_q, armed_q;

  logic [EW-1:0]    rise;
  logic [1:0]       qlvl;
  logic             src_tick, q_up, q_dn;
  logic             phase_on, cnt_up, cnt_dn, cnt_wr, cnt_clr, stat_wr;
  logic [N_GR-1:0]  cap_evt, cmp_hit, clr_pick, gr_wr;
  logic             set_evt;

  tmr_sync_edge #(.W(EW), .EDGE(1'b1)) u_edge (
    .clk(clk), .rst_n(rst_n), .din({cap_in, ext_clk}), .dout(rise)
  );

  tmr_sync_edge #(.W(2), .EDGE(1'b0)) u_qsync (
    .clk(clk), .rst_n(rst_n), .din({quad_b, quad_a}), .dout(qlvl)
  );

  tmr_tick_sel #(.N_INT(N_INT), .N_EXT(N_EXT), .SEL_W(3)) u_tick (
    .clk(clk), .rst_n(rst_n), .src(ctrl_q.src),
    .ext_rise(rise[N_EXT-1:0]), .tick(src_tick)
  );

  tmr_quad_dec u_quad (
    .clk(clk), .rst_n(rst_n), .en(phase_on),
    .pa(qlvl[0]), .pb(qlvl[1]), .up(q_up), .dn(q_dn)
  );

  assign phase_on = ctrl_q.phase;
  assign cnt_up   = phase_on ? q_up : src_tick;
  assign cnt_dn   = phase_on & q_dn;
  assign cnt_wr   = bus_wr && (bus_addr == ADDR_W'(A_CNT));
  assign stat_wr  = bus_wr && (bus_addr == ADDR_W'(A_STAT));

  // Per-register compare, capture and clear-source decoding
  generate
    for (genvar i = 0; i < N_GR; i++) begin : g_gr
      logic cap_mode;
      assign cap_mode    = (i == 0) ? ctrl_q.cap_a : ctrl_q.cap_b;
      assign cap_evt[i]  = cap_mode && rise[N_EXT+i];
      assign cmp_hit[i]  = !cap_mode && cnt_up && (cnt_q == gr_q[i]);
      assign clr_pick[i] = (ctrl_q.clr == clr_sel_e'(i + 1));
      assign gr_wr[i]    = bus_wr && (bus_addr == ADDR_W'(A_GRA + i));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          gr_q[i] <= '0;
        else if (gr_wr[i])   gr_q[i] <= bus_wdata;
        else if (cap_evt[i]) gr_q[i] <= cnt_q;
      end
    end
  endgenerate

  assign cnt_clr = |(clr_pick & (cap_evt | cmp_hit));
  assign set_evt = !cnt_wr && !cnt_clr &&
                   ((cnt_up && (cnt_q == '1)) || (cnt_dn && (cnt_q == '0)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_wr)  cnt_q <= bus_wdata;
    else if (cnt_clr) cnt_q <= '0;
    else if (cnt_up)  cnt_q <= cnt_q + 1'b1;
    else if (cnt_dn)  cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (bus_wr && (bus_addr == ADDR_W'(A_CTRL)))
      ctrl_q <= ctrl_t'(bus_wdata[$bits(ctrl_t)-1:0]);
  end

  // Flag: set has priority; clear needs a prior read that saw it set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (set_evt)                                 flag_q <= 1'b1;
      else if (stat_wr && !bus_wdata[0] && armed_q) flag_q <= 1'b0;

      if (stat_wr)                                                   armed_q <= 1'b0;
      else if (bus_rd && (bus_addr == ADDR_W'(A_STAT)) && flag_q)   armed_q <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(A_CTRL))      bus_rdata = CNT_W'(ctrl_q);
    else if (bus_addr == ADDR_W'(A_CNT))  bus_rdata = cnt_q;
    else if (bus_addr == ADDR_W'(A_GRA))  bus_rdata = gr_q[0];
    else if (bus_addr == ADDR_W'(A_GRB))  bus_rdata = gr_q[1];
    else if (bus_addr == ADDR_W'(A_STAT)) bus_rdata = CNT_W'(flag_q);
  end

  assign ovf_flag = flag_q;
endmodule

// File: rtl/timer_channel_chk.sv
module timer_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] bus_wdata,
  input logic [CNT_W-1:0] cnt_q,
  input logic             flag_q,
  input logic             armed_q,
  input logic             cnt_wr,
  input logic             cnt_clr,
  input logic             cnt_up,
  input logic             cnt_dn,
  input logic             phase_on,
  input logic             stat_wr
);
  // R3
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt_q == $past(bus_wdata));

  // R4
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_clr && !cnt_wr) |=> cnt_q == '0);

  // R6
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_up && cnt_q == '1 && !cnt_wr && !cnt_clr) |=> flag_q);

  // R8
  unf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_dn && cnt_q == '0 && !cnt_wr && !cnt_clr) |=> flag_q);

  // R7
  no_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_on |-> !cnt_dn);

  // R10
  fall_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(stat_wr));

  // R10
  fall_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(armed_q));
endmodule

bind timer_channel timer_channel_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/timer_channel_test.sv
module timer_channel_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_wdata, bus_rdata;
  logic [3:0]  ext_clk;
  logic        quad_a, quad_b;
  logic [1:0]  cap_in;
  logic        ovf_flag;

  always #(CLK_PERIOD/2) clk = ~clk;

  timer_channel uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_clk(ext_clk), .quad_a(quad_a), .quad_b(quad_b),
    .cap_in(cap_in), .ovf_flag(ovf_flag)
  );

  int n_chk = 0, n_fail = 0, qpos = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data as each scored read appears
  always @(negedge clk) begin
    #1;
    if (bus_rd && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(bus_rdata == e, t, bus_rdata, e);
    end
  end

  task automatic wr(int a, logic [15:0] d);
    bus_addr = a[2:0]; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(int a, logic [15:0] e, string t);
    bus_addr = a[2:0]; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek_cnt(output logic [15:0] v);
    bus_addr = 3'd1; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] ctrlw(int src, int clr, bit ph, bit ca, bit cb);
    return 16'((cb << 7) | (ca << 6) | (ph << 5) | ((clr & 3) << 3) | (src & 7));
  endfunction

  task automatic measure(int src, int cycles, int delta, string t);
    logic [15:0] v;
    wr(0, ctrlw(src, 0, 0, 0, 0));
    peek_cnt(v);
    idle(cycles - 1);
    rd_chk(1, v + 16'(delta), t);
  endtask

  task automatic qstep(int dir);
    qpos = (qpos + dir) & 3;
    case (qpos)
      0: {quad_a, quad_b} = 2'b00;
      1: {quad_a, quad_b} = 2'b10;
      2: {quad_a, quad_b} = 2'b11;
      default: {quad_a, quad_b} = 2'b01;
    endcase
    idle(4);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    ext_clk = '0; quad_a = 0; quad_b = 0; cap_in = '0;
    idle(3);
    rst_n = 1'b1;

    rd_chk(1, 16'h0000, "R1 counter after reset");
    rd_chk(4, 16'h0000, "R1 status after reset");
    rd_chk(2, 16'h0000, "R1 register A after reset");
    rd_chk(3, 16'h0000, "R1 register B after reset");
    rd_chk(0, 16'h0000, "R1 control after reset");

    wr(1, 16'h1234);
    rd_chk(1, 16'h1234, "R3 bus write beats count pulse");
    rd_chk(1, 16'h1235, "R3 count continues from written value");

    measure(1, 64, 32, "R2 source 1 every 2 cycles");
    measure(2, 64, 16, "R2 source 2 every 4 cycles");
    measure(3, 64, 8,  "R2 source 3 every 8 cycles");

    wr(0, ctrlw(5, 0, 0, 0, 0));
    peek_cnt(v);
    repeat (5) begin
      ext_clk = 4'b0011; idle(3);
      ext_clk = 4'b0000; idle(3);
    end
    idle(4);
    rd_chk(1, v + 16'd5, "R2 external source 5 counts only its own edges");

    wr(0, ctrlw(0, 1, 0, 0, 0));
    wr(2, 16'd9);
    wr(1, 16'd0);
    for (int i = 0; i < 12; i++) rd_chk(1, 16'(i % 10), "R4 compare A clears");
    wr(0, ctrlw(0, 0, 0, 0, 0));
    wr(1, 16'd5);
    for (int i = 0; i < 8; i++) rd_chk(1, 16'(5 + i), "R4 clear select 00 no clear");
    wr(0, ctrlw(0, 3, 0, 0, 0));
    wr(1, 16'd5);
    for (int i = 0; i < 8; i++) rd_chk(1, 16'(5 + i), "R4 clear select 11 no clear");

    wr(0, ctrlw(0, 0, 0, 0, 0));
    wr(1, 16'hFFFE);
    rd_chk(1, 16'hFFFE, "R6 before wrap");
    rd_chk(1, 16'hFFFF, "R6 at top");
    rd_chk(1, 16'h0000, "R6 wrapped");
    chk(ovf_flag == 1'b1, "R6 overflow sets flag", 16'(ovf_flag), 16'd1);

    wr(4, 16'h0000);
    chk(ovf_flag == 1'b1, "R10 write 0 without read keeps flag", 16'(ovf_flag), 16'd1);
    rd_chk(4, 16'h0001, "R10 status read sees flag");
    wr(4, 16'h0000);
    chk(ovf_flag == 1'b0, "R10 read then write clears", 16'(ovf_flag), 16'd0);
    rd_chk(4, 16'h0000, "R10 status reads clear");
    wr(1, 16'hFFFE);
    idle(3);
    wr(4, 16'h0000);
    chk(ovf_flag == 1'b1, "R10 read that saw 0 does not arm", 16'(ovf_flag), 16'd1);

    rd_chk(4, 16'h0001, "R11 arming read");
    wr(1, 16'hFFFE);
    idle(1);
    wr(4, 16'h0000);
    chk(ovf_flag == 1'b1, "R11 set beats clear in same cycle", 16'(ovf_flag), 16'd1);
    rd_chk(4, 16'h0001, "R11 flag still set");
    wr(4, 16'h0000);
    chk(ovf_flag == 1'b0, "R10 clear after collision", 16'(ovf_flag), 16'd0);

    wr(0, ctrlw(0, 1, 1, 1, 0));
    wr(1, 16'h0ABC);
    idle(2);
    cap_in[0] = 1'b1; idle(4); cap_in[0] = 1'b0; idle(4);
    rd_chk(2, 16'h0ABC, "R5 capture into A");
    rd_chk(1, 16'h0000, "R5 capture A clears counter");
    wr(0, ctrlw(0, 1, 1, 0, 1));
    wr(1, 16'h0321);
    idle(2);
    cap_in[1] = 1'b1; idle(4); cap_in[1] = 1'b0; idle(4);
    rd_chk(3, 16'h0321, "R5 capture into B");
    rd_chk(1, 16'h0321, "R5 unselected capture keeps counter");

    wr(0, ctrlw(0, 0, 1, 0, 0));
    wr(1, 16'd2);
    idle(4);
    rd_chk(1, 16'd2, "R7 clock source ignored in phase mode");
    repeat (4) qstep(1);
    rd_chk(1, 16'd6, "R7 A leading counts up");
    chk(ovf_flag == 1'b0, "R8 flag clear before underflow", 16'(ovf_flag), 16'd0);
    repeat (8) qstep(-1);
    rd_chk(1, 16'hFFFE, "R7 B leading counts down");
    chk(ovf_flag == 1'b1, "R8 underflow sets flag", 16'(ovf_flag), 16'd1);

    {quad_a, quad_b} = 2'b11; idle(4);
    rd_chk(1, 16'hFFFE, "R9 double transition 00 to 11 ignored");
    {quad_a, quad_b} = 2'b00; idle(4);
    rd_chk(1, 16'hFFFE, "R9 double transition 11 to 00 ignored");
    qpos = 0;

    idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule